// File: doc/BRIEF.md
# Burst Initiator for a Multiplexed Parallel Bus

This block is the initiator side of a shared bus that carries address and data on the same lines. A local requester asks it for a read or write burst of 1 to 16 words. The block then requests the bus and waits for the arbiter's grant. It also waits until no other initiator is using the bus. It then drives one address phase that carries the address and a bus command, and after that it sequences the data phases. A word moves on each rising edge where the initiator-ready and target-ready signals are both asserted, and the target has claimed the access.

The block marks the final data phase by releasing its frame signal while it holds initiator-ready. A burst can end in one of four ways:
- normal completion of every word;
- a stop from the target, with or without a word on the same edge;
- a target abort;
- a master abort, when no target claims the access within the select window.

When the bus is released, the local side receives a one-cycle done pulse, a 2-bit status and the number of words that moved. All bus signals are active high at the ports, so polarity conversion belongs to the pad ring.

Top module: `ibs_initiator`

## Requirements
- R1: While reset is asserted, req_o, frame_o, irdy_o, ad_oe_o and done_o are all low.
- R2: start_i in the idle state raises req_o. frame_o rises only after an edge where gnt_i was high and the bus was idle. The bus is idle when bus_frame_i and bus_irdy_i are both low.
- R3: If gnt_i is low on an edge while the block waits for the bus to go idle, the block goes back to waiting for a grant. It keeps req_o high and does not raise frame_o. It then needs a granted edge and a later granted idle edge before its address phase.
- R4: Each burst has exactly one address phase, one cycle long, with frame_o high, irdy_o low and ad_oe_o high. In that phase ad_o carries addr_i and cbe_o carries the command {0, ~io_i, 1, write_i}: 0010 is I/O read, 0011 I/O write, 0110 memory read and 0111 memory write.
- R5: In every data phase irdy_o is high and cbe_o carries ben_i. A word moves on an edge where devsel_i and trdy_i are both high. Writes drive wdata_i on ad_o with ad_oe_o high and pulse wr_next_o for each word moved. Reads pulse rd_valid_o with rdata_o equal to ad_i.
- R6: frame_o is low exactly in the final data phase, while irdy_o stays high until that phase ends. frame_o falls before irdy_o, and it does not rise again within the burst.
- R7: When the last of len_m1_i+1 words moves, done_o reports status 00 with words_o equal to the burst length.
- R8: If devsel_i and stop_i are both high, the burst ends with status 01. words_o counts a word that moved on that same edge. If frame_o was still high, one extra phase with frame_o low and irdy_o high follows, and no word moves in it.
- R9: If stop_i is high while devsel_i is low, after devsel_i was seen high earlier in the burst, the result is a target abort with status 10.
- R10: If devsel_i stays low through 6 consecutive data phases from the start, the result is a master abort with status 11 and words_o 0. A devsel_i that first rises in the 6th data phase still claims the access.
- R11: done_o is a one-cycle pulse in the cycle after the bus is released, with req_o, frame_o and irdy_o low. status_o and words_o are valid with it, and a new start_i is accepted afterwards.
- R12: A word that moves on the final phase together with stop_i ends the burst with status 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (sampled in idle) |
| write_i | input | 1 | 1 = write burst, 0 = read burst |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| addr_i | input | DW | Start address |
| len_m1_i | input | LW | Burst length minus one |
| ben_i | input | BW | Byte-enable mask for every data phase |
| wdata_i | input | DW | Current write word |
| wr_next_o | output | 1 | Write word accepted, present the next |
| rdata_o | output | DW | Read word |
| rd_valid_o | output | 1 | rdata_o holds a moved word |
| done_o | output | 1 | Burst finished (one cycle) |
| status_o | output | 2 | 00 normal, 01 target stop, 10 target abort, 11 master abort |
| words_o | output | CW | Words moved in the burst |
| req_o | output | 1 | Bus request to the arbiter |
| gnt_i | input | 1 | Bus grant |
| bus_frame_i | input | 1 | Frame as seen on the shared bus |
| bus_irdy_i | input | 1 | Initiator-ready as seen on the shared bus |
| frame_o | output | 1 | Frame driven by this initiator |
| irdy_o | output | 1 | Initiator-ready driven by this initiator |
| ad_o | output | DW | Address/data driven onto the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| cbe_o | output | BW | Command / byte enables |
| ad_i | input | DW | Address/data read from the bus |
| devsel_i | input | 1 | Target has claimed the access |
| trdy_i | input | 1 | Target ready |
| stop_i | input | 1 | Target requests termination |

## Verification
The bound checker checks several bus rules on every cycle. It checks the order in which frame and initiator-ready are released, that frame stays low once the final phase starts, and that an address phase needs a prior granted idle edge. It also checks that a transfer pulse only appears with initiator-ready high, that done is a pulse on a released bus, and that a master abort reports no words. The scenario table and the directed tests cover the rest, because those behaviours depend on the whole history of the target's answers. They cover which status each target behaviour yields and the word counts. They also cover the data and command values on the lines, the edge of the select window, and the exact cycle in which a lost grant delays the address phase.

// File: rtl/ibs_pkg.sv
`timescale 1ns/1ps
package ibs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_GNT,
    S_WAIT_IDLE,
    S_ADDR,
    S_DATA,
    S_CLOSE,
    S_FIN
  } ibs_state_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_STOP   = 2'b01,
    ST_TABORT = 2'b10,
    ST_MABORT = 2'b11
  } ibs_status_e;

  // Bus command: bit2 selects memory space, bit0 selects write.
  function automatic logic [3:0] ibs_cmd(input logic io, input logic wr);
    return {1'b0, ~io, 1'b1, wr};
  endfunction

endpackage

// File: rtl/ibs_beat_counter.sv
`timescale 1ns/1ps
module ibs_beat_counter #(
  parameter int MAX_BURST = 16,
  localparam int LW = $clog2(MAX_BURST),
  localparam int CW = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] len_m1_i,
  input  logic          step_i,
  output logic          last_o,
  output logic [CW-1:0] words_o
);

  logic [LW-1:0] rem_q, rem_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rem_d = rem_q;
    cnt_d = cnt_q;
    if (load_i) begin
      rem_d = len_m1_i;
      cnt_d = '0;
    end else if (step_i) begin
      rem_d = rem_q - 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o  = (rem_q == '0);
  assign words_o = cnt_q;

endmodule

// File: rtl/ibs_devsel_timer.sv
`timescale 1ns/1ps
module ibs_devsel_timer #(
  parameter int LIMIT = 6,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic active_i,
  input  logic devsel_i,
  output logic claimed_o,
  output logic expire_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          claim_q, claim_d;

  always_comb begin
    cnt_d   = cnt_q;
    claim_d = claim_q;
    if (clear_i) begin
      cnt_d   = '0;
      claim_d = 1'b0;
    end else if (active_i) begin
      if (devsel_i)      claim_d = 1'b1;
      else if (!claim_q) cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      claim_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      claim_q <= claim_d;
    end
  end

  assign claimed_o = claim_q;
  assign expire_o  = active_i && !claim_q && !devsel_i && (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/ibs_initiator.sv
`timescale 1ns/1ps
module ibs_initiator
  import ibs_pkg::*;
#(
  parameter int DW           = 32,
  parameter int MAX_BURST    = 16,
  parameter int DEVSEL_LIMIT = 6,
  localparam int BW = DW / 8,
  localparam int LW = $clog2(MAX_BURST),
  localparam int CW = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          write_i,
  input  logic          io_i,
  input  logic [DW-1:0] addr_i,
  input  logic [LW-1:0] len_m1_i,
  input  logic [BW-1:0] ben_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_next_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_valid_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic [CW-1:0] words_o,
  output logic          req_o,
  input  logic          gnt_i,
  input  logic          bus_frame_i,
  input  logic          bus_irdy_i,
  output logic          frame_o,
  output logic          irdy_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] cbe_o,
  input  logic [DW-1:0] ad_i,
  input  logic          devsel_i,
  input  logic          trdy_i,
  input  logic          stop_i
);

  ibs_state_e    state_q, state_d;
  ibs_status_e   stat_q, stat_d;
  logic [DW-1:0] addr_q;
  logic [BW-1:0] ben_q;
  logic          wr_q, io_q;
  logic          load;
  logic          in_data, in_addr, phase_on;
  logic          xfer, last, claimed, expire;
  logic          t_abort, t_stop, bus_idle;

  assign in_data  = (state_q == S_DATA);
  assign in_addr  = (state_q == S_ADDR);
  assign phase_on = in_data || (state_q == S_CLOSE);
  assign bus_idle = !bus_frame_i && !bus_irdy_i;
  assign xfer     = in_data && devsel_i && trdy_i;
  assign t_abort  = in_data && claimed && stop_i && !devsel_i;
  assign t_stop   = in_data && devsel_i && stop_i;

  ibs_beat_counter #(.MAX_BURST(MAX_BURST)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .len_m1_i (len_m1_i),
    .step_i   (xfer),
    .last_o   (last),
    .words_o  (words_o)
  );

  ibs_devsel_timer #(.LIMIT(DEVSEL_LIMIT)) u_dsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (in_addr),
    .active_i  (in_data),
    .devsel_i  (devsel_i),
    .claimed_o (claimed),
    .expire_o  (expire)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    load    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        load    = 1'b1;
        state_d = S_WAIT_GNT;
      end
      S_WAIT_GNT:  if (gnt_i) state_d = S_WAIT_IDLE;
      S_WAIT_IDLE: begin
        if (!gnt_i)        state_d = S_WAIT_GNT;
        else if (bus_idle) state_d = S_ADDR;
      end
      S_ADDR: state_d = S_DATA;
      S_DATA: begin
        if (expire) begin
          stat_d  = ST_MABORT;
          state_d = last ? S_FIN : S_CLOSE;
        end else if (t_abort) begin
          stat_d  = ST_TABORT;
          state_d = last ? S_FIN : S_CLOSE;
        end else if (xfer && last) begin
          stat_d  = ST_OK;
          state_d = S_FIN;
        end else if (t_stop) begin
          stat_d  = ST_STOP;
          state_d = last ? S_FIN : S_CLOSE;
        end
      end
      S_CLOSE: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // State and request registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stat_q  <= ST_OK;
      addr_q  <= '0;
      ben_q   <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      if (load) begin
        addr_q <= addr_i;
        ben_q  <= ben_i;
        wr_q   <= write_i;
        io_q   <= io_i;
      end
    end
  end

  // Bus and local outputs
  always_comb begin
    req_o   = (state_q == S_WAIT_GNT) || (state_q == S_WAIT_IDLE);
    frame_o = in_addr || (in_data && !last);
    irdy_o  = phase_on;
    ad_oe_o = in_addr || (phase_on && wr_q);
    ad_o    = '0;
    cbe_o   = '0;
    if (in_addr) begin
      ad_o  = addr_q;
      cbe_o = BW'(ibs_cmd(io_q, wr_q));
    end else if (phase_on) begin
      cbe_o = ben_q;
      if (wr_q) ad_o = wdata_i;
    end
  end

  assign wr_next_o  = xfer && wr_q;
  assign rd_valid_o = xfer && !wr_q;
  assign rdata_o    = ad_i;
  assign done_o     = (state_q == S_FIN);
  assign status_o   = stat_q;

endmodule

// File: rtl/ibs_initiator_chk.sv
`timescale 1ns/1ps
module ibs_initiator_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt_i,
  input logic          bus_frame_i,
  input logic          bus_irdy_i,
  input logic          req_o,
  input logic          frame_o,
  input logic          irdy_o,
  input logic          ad_oe_o,
  input logic          wr_next_o,
  input logic          rd_valid_o,
  input logic          done_o,
  input logic [1:0]    status_o,
  input logic [CW-1:0] words_o
);

  a_r2_frame_after_granted_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> ($past(gnt_i) && !$past(bus_frame_i) && !$past(bus_irdy_i)));

  a_r4_addr_phase_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> (!irdy_o && ad_oe_o));

  a_r4_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |=> irdy_o);

  a_r5_moves_need_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_next_o || rd_valid_o) |-> irdy_o);

  a_r6_frame_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irdy_o) |-> !$past(frame_o));

  a_r6_final_phase_frame_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_o && !frame_o) |=> !frame_o);

  a_r10_master_abort_no_words: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 2'b11) |-> (words_o == '0));

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_done_on_released_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!frame_o && !irdy_o && !req_o));

endmodule

bind ibs_initiator ibs_initiator_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gnt_i       (gnt_i),
  .bus_frame_i (bus_frame_i),
  .bus_irdy_i  (bus_irdy_i),
  .req_o       (req_o),
  .frame_o     (frame_o),
  .irdy_o      (irdy_o),
  .ad_oe_o     (ad_oe_o),
  .wr_next_o   (wr_next_o),
  .rd_valid_o  (rd_valid_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .words_o     (words_o)
);

// File: tb/tb_ibs_initiator.sv
`timescale 1ns/1ps
module tb_ibs_initiator;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int LW = 4;
  localparam int CW = 5;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic [3:0] lm1;
    logic [2:0] dly;    // data phase in which devsel first rises (7 = never)
    logic [1:0] mode;   // 0 plain, 1 stop with word, 2 stop without word, 3 abort
    logic [4:0] k;      // word index at which the target acts
    logic [1:0] est;
    logic [4:0] ewords;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 4'd0,  3'd1, 2'd0, 5'd0, 2'd0, 5'd1},
    '{1'b0, 1'b0, 4'd3,  3'd1, 2'd0, 5'd0, 2'd0, 5'd4},
    '{1'b1, 1'b1, 4'd15, 3'd2, 2'd0, 5'd0, 2'd0, 5'd16},
    '{1'b0, 1'b1, 4'd2,  3'd6, 2'd0, 5'd0, 2'd0, 5'd3},
    '{1'b0, 1'b0, 4'd3,  3'd7, 2'd0, 5'd0, 2'd3, 5'd0},
    '{1'b1, 1'b0, 4'd0,  3'd7, 2'd0, 5'd0, 2'd3, 5'd0},
    '{1'b1, 1'b0, 4'd7,  3'd1, 2'd1, 5'd2, 2'd1, 5'd3},
    '{1'b0, 1'b0, 4'd5,  3'd2, 2'd2, 5'd0, 2'd1, 5'd0},
    '{1'b1, 1'b1, 4'd3,  3'd1, 2'd3, 5'd1, 2'd2, 5'd1},
    '{1'b0, 1'b0, 4'd1,  3'd1, 2'd1, 5'd1, 2'd0, 5'd2},
    '{1'b0, 1'b0, 4'd1,  3'd1, 2'd3, 5'd1, 2'd2, 5'd1}
  };

  logic clk;
  logic rst_n;
  logic start_i, write_i, io_i;
  logic [DW-1:0] addr_i, wdata_i, rdata_o, ad_o, ad_i;
  logic [LW-1:0] len_m1_i;
  logic [BW-1:0] ben_i, cbe_o;
  logic wr_next_o, rd_valid_o, done_o;
  logic [1:0] status_o;
  logic [CW-1:0] words_o;
  logic req_o, gnt_i, bus_frame_i, bus_irdy_i;
  logic frame_o, irdy_o, ad_oe_o;
  logic devsel_i, trdy_i, stop_i;

  int checks = 0;
  int failures = 0;

  ibs_initiator dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i), .io_i(io_i),
    .addr_i(addr_i), .len_m1_i(len_m1_i), .ben_i(ben_i), .wdata_i(wdata_i),
    .wr_next_o(wr_next_o), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
    .done_o(done_o), .status_o(status_o), .words_o(words_o), .req_o(req_o),
    .gnt_i(gnt_i), .bus_frame_i(bus_frame_i), .bus_irdy_i(bus_irdy_i),
    .frame_o(frame_o), .irdy_o(irdy_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .cbe_o(cbe_o), .ad_i(ad_i), .devsel_i(devsel_i), .trdy_i(trdy_i), .stop_i(stop_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5 * 150000);
    failures++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int idx, input int n);
    return 32'hA500_0000 + 32'(idx * 256 + n);
  endfunction

  function automatic logic [3:0] mask(input int idx);
    return 4'hF ^ 4'(idx);
  endfunction

  task automatic kick(input vec_t v, input int idx);
    @(negedge clk);
    write_i  = v.wr;
    io_i     = v.io;
    addr_i   = 32'h1000_0000 + 32'(idx * 64);
    len_m1_i = v.lm1;
    ben_i    = mask(idx);
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic serve(input vec_t v, input int idx);
    int  n = 0;
    int  d = 0;
    int  nad = 0;
    bit  term = 1'b0;
    bit  dxf = 1'b0;
    bit  dev = 1'b0;
    bit  tr = 1'b0;
    bit  st = 1'b0;
    bit  fin = 1'b0;
    bit  tprev;
    logic [3:0] cmd;
    string tg;
    gnt_i = 1'b1; bus_frame_i = 1'b0; bus_irdy_i = 1'b0;
    cmd = {1'b0, ~v.io, 1'b1, v.wr};
    for (int it = 0; it < 80 && !fin; it++) begin
      @(negedge clk);
      if (done_o) begin
        tg = (v.est == 2'd0) ? "R7" : (v.est == 2'd1) ? "R8" : (v.est == 2'd2) ? "R9" : "R10";
        if (idx == 9) tg = "R12";
        chk(status_o == v.est, {tg, " status"}, 32'(status_o), 32'(v.est));
        chk(words_o == v.ewords, {tg, " words"}, 32'(words_o), 32'(v.ewords));
        chk(!frame_o && !irdy_o && !req_o, "R11 bus released at done",
            {29'd0, frame_o, irdy_o, req_o}, 32'd0);
        fin = 1'b1;
        devsel_i = 1'b0; trdy_i = 1'b0; stop_i = 1'b0;
      end else if (frame_o && !irdy_o) begin
        nad++;
        chk(ad_o == addr_i, "R4 address", ad_o, addr_i);
        chk(cbe_o == cmd, "R4 command", 32'(cbe_o), 32'(cmd));
        chk(ad_oe_o, "R4 drive enable", 32'(ad_oe_o), 32'd1);
      end else if (irdy_o) begin
        if (dxf) n++;
        d++;
        tprev = term;
        chk(frame_o == (!term && (n != int'(v.lm1))), "R6 frame in data phase",
            32'(frame_o), 32'(!term && (n != int'(v.lm1))));
        chk(cbe_o == mask(idx), "R5 byte enables", 32'(cbe_o), 32'(mask(idx)));
        if (term) begin
          tr = 1'b0;
        end else begin
          dev = (d >= int'(v.dly));
          tr  = dev;
          st  = 1'b0;
          if (v.mode == 2'd1 && n == int'(v.k) && dev) st = 1'b1;
          if (v.mode == 2'd2 && n == int'(v.k) && dev) begin st = 1'b1; tr = 1'b0; end
          if (v.mode == 2'd3 && n == int'(v.k) && d > int'(v.dly)) begin
            dev = 1'b0; tr = 1'b0; st = 1'b1;
          end
          if (st || (d == 6 && !dev)) term = 1'b1;
        end
        dxf = dev && tr;
        devsel_i = dev; trdy_i = tr; stop_i = st;
        wdata_i = pat(idx, n);
        ad_i    = pat(idx, n);
        #1;
        if (!tprev && v.wr) begin
          chk(ad_o == pat(idx, n), "R5 write data", ad_o, pat(idx, n));
          chk(ad_oe_o, "R5 write drive enable", 32'(ad_oe_o), 32'd1);
        end
        if (!tprev && dxf) begin
          chk(wr_next_o == v.wr && rd_valid_o == !v.wr, "R5 word strobes",
              {30'd0, wr_next_o, rd_valid_o}, {30'd0, v.wr, !v.wr});
          if (!v.wr) chk(rdata_o == pat(idx, n), "R5 read data", rdata_o, pat(idx, n));
        end
        if (tprev) chk(!wr_next_o && !rd_valid_o, "R8 no word in closing phase",
                       {30'd0, wr_next_o, rd_valid_o}, 32'd0);
      end else begin
        devsel_i = 1'b0; trdy_i = 1'b0; stop_i = 1'b0;
      end
    end
    chk(fin, "R11 done seen", 32'(fin), 32'd1);
    chk(nad == 1, "R4 one address phase", 32'(nad), 32'd1);
    gnt_i = 1'b0;
    @(negedge clk);
    chk(!done_o, "R11 done lasts one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0; write_i = 1'b0; io_i = 1'b0; addr_i = '0; len_m1_i = '0;
    ben_i = '0; wdata_i = '0; ad_i = '0; gnt_i = 1'b0; bus_frame_i = 1'b0;
    bus_irdy_i = 1'b0; devsel_i = 1'b0; trdy_i = 1'b0; stop_i = 1'b0;

    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk(!req_o && !frame_o && !irdy_o && !ad_oe_o && !done_o, "R1 reset outputs",
        {27'd0, req_o, frame_o, irdy_o, ad_oe_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_o && !frame_o && !irdy_o, "R1 idle after release",
        {29'd0, req_o, frame_o, irdy_o}, 32'd0);

    // Scenario table
    for (int i = 0; i < NV; i++) begin
      kick(VEC[i], i);
      serve(VEC[i], i);
    end

    // Directed: grant and idle-bus handling (R2, R3)
    kick(VEC[1], 20);
    gnt_i = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(req_o && !frame_o, "R2 request held without grant", {30'd0, req_o, frame_o}, 32'd2);
    end
    gnt_i = 1'b1; bus_irdy_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!frame_o, "R2 waits while initiator-ready busy", 32'(frame_o), 32'd0);
    end
    bus_irdy_i = 1'b0; bus_frame_i = 1'b1;
    @(negedge clk);
    chk(!frame_o, "R2 waits while frame busy", 32'(frame_o), 32'd0);
    gnt_i = 1'b0;
    @(negedge clk);
    chk(req_o && !frame_o, "R3 grant lost keeps request", {30'd0, req_o, frame_o}, 32'd2);
    gnt_i = 1'b1; bus_frame_i = 1'b0;
    @(negedge clk);
    chk(!frame_o, "R3 needs a fresh grant edge", 32'(frame_o), 32'd0);
    serve(VEC[1], 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule